// File: doc/BRIEF.md
# Upgrade Control Shift/Capture Register

This block is the serial-access register pair in front of a configuration-upgrade controller. A serial shift chain carries control words in and status words out, least significant bit first. Two select bits sit above the chain and choose which status word a capture loads. A parallel input register holds the control word that the rest of the controller acts on.

Two mode controls pick the operation on each clock edge. With the shift control high, the chain shifts. With both controls low, the chain's contents are copied into the input register. With only the capture control high, the chain is loaded from one of four sources: the current-state word, either of two zero-padded previous-state words, or the input register itself. The select bits follow a dedicated source input while the chain shifts and hold their value otherwise. The input register drives an image-select output. Its override bit decides whether the image choice comes from the register or from the external pin.

Top module: `upg_ctl_reg`

## Requirements
- R1: A synchronous active-high reset clears the 39-bit chain, the select bits and the input register to zero. Afterwards `ser_out` is 0, `ovr_active` is 0 and `img_sel` equals `pin_img_sel`.
- R2: While `shift_en` is 1, each rising edge loads chain bits [38:0] with {`ser_in`, chain[38:1]}. `ser_out` always shows chain bit 0. `cap_en` has no effect while `shift_en` is 1.
- R3: With `shift_en`=0 and `cap_en`=0, the input register loads chain bits [38:0] on the rising edge. In every other mode the input register keeps its value.
- R4: With `shift_en`=0, `cap_en`=1 and select bits 2'b00, the chain loads `cur_state`.
- R5: With select bits 2'b01, a capture loads {8'b0, `prev_app1`}.
- R6: With select bits 2'b10, a capture loads {8'b0, `prev_app2`}.
- R7: With select bits 2'b11, a capture loads the current contents of the input register.
- R8: The two select bits take the value of `cap_src` on every shifting edge. They keep their value during capture, update and idle edges.
- R9: `ovr_active` equals input register bit 12. When bit 12 is 1, `img_sel` equals input register bit 13. When bit 12 is 0, `img_sel` equals `pin_img_sel` and bit 13 is ignored.
- R10: Input register bits 38:14 are reserved and have no effect on `img_sel` or `ovr_active`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both registers |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | 1: shift the chain; 0: capture or update |
| cap_en | input | 1 | When not shifting, 1: capture, 0: update |
| cap_src | input | 2 | Source code copied into the select bits while shifting |
| ser_in | input | 1 | Serial data entering chain bit 38 |
| ser_out | output | 1 | Chain bit 0 |
| cur_state | input | 39 | Current-state status word |
| prev_app1 | input | 31 | Previous-state word of application 1 |
| prev_app2 | input | 31 | Previous-state word of application 2 |
| pin_img_sel | input | 1 | External image-select pin |
| img_sel | output | 1 | Effective image select |
| ovr_active | output | 1 | Input register override bit |

## Verification
A capture or an update takes effect on the edge where the mode is applied. After an update, `img_sel` and `ovr_active` are valid in that same cycle, so the bench checks them 2 ns after that edge. A captured word appears at `ser_out` immediately after the capture edge and then advances one bit per shifting edge. The monitor therefore samples `ser_out` at each falling edge across exactly 39 cycles and compares the assembled word with the oldest expected word in the queue. Inputs change 2 ns after rising edges, so the samples and the drives never share an edge.

// File: rtl/upg_ctl_pkg.sv
package upg_ctl_pkg;

   typedef enum logic [1:0] {
      OP_UPDATE  = 2'b00,
      OP_CAPTURE = 2'b01,
      OP_SHIFT   = 2'b10
   } op_e;

   typedef enum logic [1:0] {
      SRC_CUR   = 2'b00,
      SRC_PREV1 = 2'b01,
      SRC_PREV2 = 2'b10,
      SRC_HELD  = 2'b11
   } src_e;

   function automatic op_e decode_op(input logic shift_mode, input logic capture_mode);
      if (shift_mode) return OP_SHIFT;
      if (capture_mode) return OP_CAPTURE;
      return OP_UPDATE;
   endfunction

endpackage

// File: rtl/upg_capture_mux.sv
module upg_capture_mux
   import upg_ctl_pkg::*;
#(
   parameter int DATA_W = 39,
   parameter int PREV_W = 31
) (
   input  src_e              src,
   input  logic [DATA_W-1:0] cur,
   input  logic [PREV_W-1:0] prev1,
   input  logic [PREV_W-1:0] prev2,
   input  logic [DATA_W-1:0] held,
   output logic [DATA_W-1:0] word
);
   localparam int PAD_W = DATA_W - PREV_W;

   logic [DATA_W-1:0] prev1_w;
   logic [DATA_W-1:0] prev2_w;

   generate
      if (PAD_W < 0) begin : g_bad
         $error("PREV_W must not exceed DATA_W");
      end else if (PAD_W == 0) begin : g_nopad
         assign prev1_w = prev1;
         assign prev2_w = prev2;
      end else begin : g_pad
         assign prev1_w = {{PAD_W{1'b0}}, prev1};
         assign prev2_w = {{PAD_W{1'b0}}, prev2};
      end
   endgenerate

   always_comb begin
      case (src)
         SRC_CUR:   word = cur;
         SRC_PREV1: word = prev1_w;
         SRC_PREV2: word = prev2_w;
         default:   word = held;
      endcase
   end
endmodule

// File: rtl/upg_shift_chain.sv
module upg_shift_chain
   import upg_ctl_pkg::*;
#(
   parameter int DATA_W = 39
) (
   input  logic              clk,
   input  logic              rst,
   input  op_e               op,
   input  logic [1:0]        src_in,
   input  logic              ser_in,
   input  logic [DATA_W-1:0] cap_word,
   output logic [DATA_W-1:0] chain,
   output src_e              sel
);
   generate
      if (DATA_W < 2) begin : g_bad
         $error("DATA_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         chain <= '0;
         sel   <= SRC_CUR;
      end else begin
         case (op)
            OP_SHIFT: begin
               chain <= {ser_in, chain[DATA_W-1:1]};
               sel   <= src_e'(src_in);
            end
            OP_CAPTURE: chain <= cap_word;
            default: ;
         endcase
      end
   end

   // R2
   shift_path_chk: assert property (@(posedge clk) disable iff (rst)
      op == OP_SHIFT |=> chain[DATA_W-1] == $past(ser_in)
                         && chain[DATA_W-2:0] == $past(chain[DATA_W-1:1]));

   // R8
   sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
      op != OP_SHIFT |=> $stable(sel));

   // R4
   capture_load_chk: assert property (@(posedge clk) disable iff (rst)
      op == OP_CAPTURE |=> chain == $past(cap_word));
endmodule

// File: rtl/upg_input_reg.sv
module upg_input_reg
   import upg_ctl_pkg::*;
#(
   parameter int DATA_W = 39
) (
   input  logic              clk,
   input  logic              rst,
   input  op_e               op,
   input  logic [DATA_W-1:0] load_word,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (op == OP_UPDATE) q <= load_word;
   end

   // R3
   update_load_chk: assert property (@(posedge clk) disable iff (rst)
      op == OP_UPDATE |=> q == $past(load_word));

   // R3
   input_hold_chk: assert property (@(posedge clk) disable iff (rst)
      op != OP_UPDATE |=> $stable(q));
endmodule

// File: rtl/upg_image_decode.sv
module upg_image_decode (
   input  logic ovr_bit,
   input  logic img_bit,
   input  logic pin,
   output logic img_sel,
   output logic ovr_active
);
   assign ovr_active = ovr_bit;
   assign img_sel    = ovr_bit ? img_bit : pin;
endmodule

// File: rtl/upg_ctl_reg.sv
module upg_ctl_reg
   import upg_ctl_pkg::*;
#(
   parameter int DATA_W  = 39,
   parameter int PREV_W  = 31,
   parameter int OVR_BIT = 12,
   parameter int IMG_BIT = 13
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              shift_en,
   input  logic              cap_en,
   input  logic [1:0]        cap_src,
   input  logic              ser_in,
   output logic              ser_out,
   input  logic [DATA_W-1:0] cur_state,
   input  logic [PREV_W-1:0] prev_app1,
   input  logic [PREV_W-1:0] prev_app2,
   input  logic              pin_img_sel,
   output logic              img_sel,
   output logic              ovr_active
);
   generate
      if (OVR_BIT >= DATA_W || IMG_BIT >= DATA_W || OVR_BIT == IMG_BIT) begin : g_bad
         $error("control bit positions must be distinct and inside DATA_W");
      end
   endgenerate

   op_e               op;
   src_e              sel;
   logic [DATA_W-1:0] chain;
   logic [DATA_W-1:0] in_q;
   logic [DATA_W-1:0] cap_word;

   assign op      = decode_op(shift_en, cap_en);
   assign ser_out = chain[0];

   upg_capture_mux #(.DATA_W(DATA_W), .PREV_W(PREV_W)) u_mux (
      .src(sel), .cur(cur_state), .prev1(prev_app1), .prev2(prev_app2),
      .held(in_q), .word(cap_word)
   );

   upg_shift_chain #(.DATA_W(DATA_W)) u_chain (
      .clk(clk), .rst(rst), .op(op), .src_in(cap_src), .ser_in(ser_in),
      .cap_word(cap_word), .chain(chain), .sel(sel)
   );

   upg_input_reg #(.DATA_W(DATA_W)) u_inreg (
      .clk(clk), .rst(rst), .op(op), .load_word(chain), .q(in_q)
   );

   upg_image_decode u_dec (
      .ovr_bit(in_q[OVR_BIT]), .img_bit(in_q[IMG_BIT]), .pin(pin_img_sel),
      .img_sel(img_sel), .ovr_active(ovr_active)
   );

   // R9
   pin_follow_chk: assert property (@(posedge clk) disable iff (rst)
      !ovr_active |-> img_sel == pin_img_sel);

   // R7
   held_capture_chk: assert property (@(posedge clk) disable iff (rst)
      (op == OP_CAPTURE && sel == SRC_HELD) |=> chain == $past(in_q));
endmodule

// File: tb/upg_ctl_reg_test.sv
module upg_ctl_reg_test;
   localparam int W = 39;

   logic clk = 0;
   logic rst = 1;
   logic shift_en = 0, cap_en = 0, ser_in = 0, pin_img_sel = 1;
   logic [1:0] cap_src = 2'b00;
   logic [W-1:0] cur_state = '0;
   logic [30:0] prev_app1 = 31'h2BAD_F00D;
   logic [30:0] prev_app2 = 31'h7135_9ACE;
   logic ser_out, img_sel, ovr_active;

   int checks = 0, errors = 0;
   logic rd_active = 0;
   bit done = 0;
   logic [W-1:0] exp_q[$];
   string tag_q[$];
   logic [W-1:0] acc;
   int cnt = 0;

   always #4 clk = ~clk;

   upg_ctl_reg uut (
      .clk(clk), .rst(rst), .shift_en(shift_en), .cap_en(cap_en), .cap_src(cap_src),
      .ser_in(ser_in), .ser_out(ser_out), .cur_state(cur_state),
      .prev_app1(prev_app1), .prev_app2(prev_app2), .pin_img_sel(pin_img_sel),
      .img_sel(img_sel), .ovr_active(ovr_active)
   );

   task automatic chk(string tag, logic [W-1:0] got, logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // monitor: assemble serial word, pop expectation, compare
   always @(negedge clk) begin
      if (rd_active) begin
         acc[cnt] = ser_out;
         cnt++;
         if (cnt == W) begin
            cnt = 0;
            if (exp_q.size() == 0) begin
               checks++; errors++;
               $display("FAIL monitor: word %h with no expectation", acc);
            end else begin
               chk(tag_q.pop_front(), acc, exp_q.pop_front());
            end
         end
      end
   end

   task automatic shift_in(logic [W-1:0] v, logic [1:0] src, logic ce);
      shift_en = 1; cap_en = ce; cap_src = src;
      for (int i = 0; i < W; i++) begin
         ser_in = v[i];
         @(posedge clk); #2;
      end
      shift_en = 0; cap_en = 0; ser_in = 0;
   endtask

   task automatic update();
      shift_en = 0; cap_en = 0;
      @(posedge clk); #2;
   endtask

   task automatic capture();
      shift_en = 0; cap_en = 1;
      @(posedge clk); #2;
      cap_en = 0;
   endtask

   task automatic readout(logic [W-1:0] exp, string tag, logic [1:0] next_src);
      exp_q.push_back(exp); tag_q.push_back(tag);
      shift_en = 1; cap_src = next_src; ser_in = 0; rd_active = 1;
      repeat (W) @(posedge clk);
      #2; rd_active = 0; shift_en = 0;
      shift_en = 0; cap_en = 0;
      update_idle();
   endtask

   task automatic update_idle();
      cap_en = 1; shift_en = 1; cap_en = 0; shift_en = 0; cap_en = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(8 * 100000);
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [W-1:0] cur_a, cur_b, wv, xv;
      cur_a = 39'h12_3456_789A;
      cur_b = 39'h6E_D0C9_8A71;
      wv    = 39'h00_0000_3A5C; // bit13=1, bit12=1
      xv    = 39'h55_AAAA_5555;
      cur_state = cur_a;
      repeat (3) @(posedge clk);
      #2; rst = 0;

      // R1 reset state
      chk("R1 ser_out", {38'b0, ser_out}, 0);
      chk("R1 ovr_active", {38'b0, ovr_active}, 0);
      chk("R1 img_sel follows pin", {38'b0, img_sel}, {38'b0, pin_img_sel});
      readout('0, "R1 chain zero", 2'b11);
      capture();
      readout('0, "R1 input register zero", 2'b00);

      // R4, R5, R6 capture sources
      capture();
      readout(cur_a, "R4 current state", 2'b01);
      capture();
      readout({8'b0, prev_app1}, "R5 previous app1", 2'b10);
      capture();
      readout({8'b0, prev_app2}, "R6 previous app2", 2'b00);
      cur_state = cur_b;
      capture();
      readout(cur_b, "R4 second current state", 2'b00);

      // R2 shift with cap_en high has no effect
      shift_in(xv, 2'b00, 1'b1);
      readout(xv, "R2 shift ignores cap_en", 2'b00);

      // R3, R9 update then override decoding
      pin_img_sel = 0;
      shift_in(wv, 2'b11, 1'b0);
      update();
      chk("R9 ovr_active set", {38'b0, ovr_active}, 1);
      chk("R9 img_sel from bit13", {38'b0, img_sel}, 1);
      // R3 and R7: shift other data, input register keeps value
      shift_in(xv, 2'b11, 1'b0);
      capture();
      readout(wv, "R7 R3 held input register", 2'b01);

      // R8 select bits hold while cap_src changes when idle
      cap_src = 2'b10;
      repeat (3) @(posedge clk);
      #2;
      capture();
      readout({8'b0, prev_app1}, "R8 select held", 2'b00);

      // R9 override on, bit13 = 0, pin = 1
      shift_in(39'h00_0000_1000, 2'b00, 1'b0);
      update();
      pin_img_sel = 1; #1;
      chk("R9 override picks image 0", {38'b0, img_sel}, 0);

      // R9 override off, bit13 = 1 ignored
      shift_in(39'h00_0000_2000, 2'b00, 1'b0);
      update();
      pin_img_sel = 0; #1;
      chk("R9 bit13 ignored pin 0", {38'b0, img_sel}, 0);
      pin_img_sel = 1; #1;
      chk("R9 bit13 ignored pin 1", {38'b0, img_sel}, 1);

      // R10 reserved bits all ones, override off
      shift_in(39'h7F_FFFF_C000, 2'b00, 1'b0);
      update();
      pin_img_sel = 0; #1;
      chk("R10 reserved ovr_active", {38'b0, ovr_active}, 0);
      chk("R10 reserved img_sel", {38'b0, img_sel}, 0);
      // R10 reserved ones with override on, bit13 = 0, pin 1
      shift_in(39'h7F_FFFF_D000, 2'b00, 1'b0);
      update();
      pin_img_sel = 1; #1;
      chk("R10 reserved with override", {38'b0, img_sel}, 0);

      repeat (4) @(posedge clk);
      if (exp_q.size() != 0) begin
         checks++; errors++;
         $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
      end
      finish_run();
   end
endmodule